// File: doc/BRIEF.md
# Low-Speed USB Device Packet Dispatcher

This block decides what a minimal low-speed USB device does with every packet its receiver has just finished. The receiver presents a one-cycle done strobe together with the packet length and the first two bytes. The first byte is the PID and the second byte holds the address field. In the following cycle the dispatcher issues at most one reply request to the transmitter. The reply is a handshake (ACK or NAK) or the queued data packet. The dispatcher also keeps the bookkeeping that the device firmware sees: which of two receive buffers the receiver fills next, the length and token of the last accepted data packet, and the length of the one transmit buffer.

The firmware and the dispatcher hand buffers over by length. A non-zero receive length means a packet is waiting for the firmware, and a release strobe frees it. A zero transmit length means the firmware may queue new data, and a load strobe queues it. Data packets are recognised before the address is examined, so the shortest reply path stays short. A SETUP or OUT token addressed to the device is remembered so that the data packet after it can be accepted. While the transmitter is busy, finished packets are refused and flagged.

Top module: `usbd_dispatcher`

## Requirements
- R1: After reset, reply_valid, reply_kind, ovr_err, rx_len, rx_token, rx_sel and tx_len are all zero.
- R2: A packet with a length below 3 bytes gets no reply, changes no buffer state and clears the remembered token.
- R3: A DATA0 (0xC3) or DATA1 (0x4B) packet is handled without looking at its second byte, so a non-matching address byte does not stop it from being accepted.
- R4: A non-data packet whose second byte's low 7 bits differ from dev_addr, or any addressed PID other than IN, OUT or SETUP, gets no reply and clears the remembered token.
- R5: A SETUP (0x2D) or OUT (0xE1) packet addressed to the device stores its PID as the remembered token and gets no reply.
- R6: A data packet that arrives while no token is remembered gets no reply and changes no buffer state.
- R7: A data packet that follows a remembered token while rx_len is non-zero is answered with NAK (reply_kind 2), and the receive state is left unchanged.
- R8: A data packet that follows a remembered token while rx_len is zero is answered with ACK (reply_kind 1). In the same cycle rx_len takes the packet length, rx_token takes the remembered PID, and rx_sel toggles.
- R9: An addressed IN (0x69) packet is answered with NAK when tx_len is zero or rx_len is non-zero.
- R10: An addressed IN packet that meets neither NAK condition is answered with a data reply (reply_kind 3), and tx_len becomes zero.
- R11: A reply is a single-cycle reply_valid pulse in the cycle right after the accepted pkt_done. reply_kind is 0 whenever reply_valid is low.
- R12: A pkt_done that arrives while tx_busy is high raises ovr_err for one cycle in the next cycle. It produces no reply and changes neither the token nor any buffer state.
- R13: rx_release clears rx_len and rx_token. tx_load sets tx_len to tx_load_len only when tx_len is zero, and is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 7 | Assigned device address |
| pkt_done | input | 1 | One-cycle strobe: a received packet is complete |
| pkt_len | input | LEN_W | Byte count of the received packet |
| pkt_pid | input | 8 | First byte of the packet (PID) |
| pkt_addr | input | 8 | Second byte of the packet (address in bits 6:0) |
| tx_busy | input | 1 | Transmitter is sending a reply |
| rx_release | input | 1 | Firmware has consumed the pending receive packet |
| tx_load | input | 1 | Firmware queues transmit data |
| tx_load_len | input | LEN_W | Length of the queued transmit data |
| reply_valid | output | 1 | One-cycle reply request to the transmitter |
| reply_kind | output | 2 | 0 none, 1 ACK, 2 NAK, 3 data packet |
| ovr_err | output | 1 | Packet refused because the transmitter was busy |
| rx_len | output | LEN_W | Length of the pending receive packet, 0 when free |
| rx_token | output | 8 | PID of the token that preceded the pending packet |
| rx_sel | output | 1 | Receive buffer the receiver fills next |
| tx_len | output | LEN_W | Queued transmit length, 0 when empty |

## Verification
A wrong remembered token never shows up directly at the ports. It shows up as the wrong outcome for the next data packet: a missing ACK, an ACK where no reply was due, or the wrong rx_token value, visible in the cycle after that packet's pkt_done. Buffer-state faults show up in the same cycle as the reply. Examples are a toggle of rx_sel that did not happen, a length that was not stored, or a tx_len that was not cleared. A refusal fault while the transmitter is busy shows up one cycle after the strobe as a missing ovr_err or a reply that should not be there. Every pair of packet types is therefore run in sequence, each under several firmware buffer states, so that every token fault is exposed by the packet that follows it.

// File: rtl/usbd_disp_pkg.sv
// Shared constants and types for the packet dispatcher.
// Assumes PID bytes arrive exactly as received (check nibble included).
package usbd_disp_pkg;
    localparam logic [7:0] PID_OUT   = 8'hE1;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_DATA1 = 8'h4B;

    typedef enum logic [1:0] {
        RPL_NONE = 2'd0,
        RPL_ACK  = 2'd1,
        RPL_NAK  = 2'd2,
        RPL_DATA = 2'd3
    } reply_e;

    typedef struct packed {
        logic len_ok;
        logic is_data;
        logic is_in;
        logic is_setup_out;
        logic addr_ok;
    } pkt_class_t;
endpackage

// File: rtl/usbd_pid_decode.sv
// Classifies a finished packet from its first two bytes and its length.
// Purely combinational. Assumes the inputs are stable while pkt_done is high.
module usbd_pid_decode
    import usbd_disp_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 3
) (
    input  logic [7:0]       pid,
    input  logic [7:0]       addr_byte,
    input  logic [6:0]       dev_addr,
    input  logic [LEN_W-1:0] pkt_len,
    output pkt_class_t       cls
);
    localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

    // Field decode: length floor, PID groups, low-7-bit address match.
    always_comb begin
        cls.len_ok       = (pkt_len >= MIN_LEN_V);
        cls.is_data      = (pid == PID_DATA0) || (pid == PID_DATA1);
        cls.is_in        = (pid == PID_IN);
        cls.is_setup_out = (pid == PID_SETUP) || (pid == PID_OUT);
        cls.addr_ok      = (addr_byte[6:0] == dev_addr);
    end
endmodule

// File: rtl/usbd_buf_state.sv
// Holds the firmware-visible buffer state: the pending receive length and
// token, the ping-pong select, and the transmit length.
// Assumes the core stores only when rx_len is zero and takes only when
// tx_len is non-zero, so those actions never collide with the firmware strobes.
module usbd_buf_state #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en,
    input  logic [LEN_W-1:0] store_len,
    input  logic [7:0]       store_tok,
    input  logic             tx_take,
    input  logic             rx_release,
    input  logic             tx_load,
    input  logic [LEN_W-1:0] tx_load_len,
    output logic [LEN_W-1:0] rx_len,
    output logic [7:0]       rx_token,
    output logic             rx_sel,
    output logic [LEN_W-1:0] tx_len
);
    // Receive side: accept a data packet and switch buffers, or free on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_len   <= '0;
            rx_token <= '0;
            rx_sel   <= 1'b0;
        end else if (store_en) begin
            rx_len   <= store_len;
            rx_token <= store_tok;
            rx_sel   <= ~rx_sel;
        end else if (rx_release) begin
            rx_len   <= '0;
            rx_token <= '0;
        end
    end

    // Transmit side: empty on a data reply, load only into an empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_len <= '0;
        end else if (tx_take) begin
            tx_len <= '0;
        end else if (tx_load && (tx_len == '0)) begin
            tx_len <= tx_load_len;
        end
    end
endmodule

// File: rtl/usbd_dispatch_core.sv
// Decides the reply for each finished packet and keeps the remembered token.
// The order of tests is fixed: length, data PIDs, address, then token PIDs.
// Assumes pkt_done is a single-cycle strobe. A strobe seen while tx_busy is
// high is refused and flagged.
module usbd_dispatch_core
    import usbd_disp_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             tx_busy,
    input  pkt_class_t       cls,
    input  logic [7:0]       pid,
    input  logic [LEN_W-1:0] rx_len,
    input  logic [LEN_W-1:0] tx_len,
    output logic             store_en,
    output logic             tx_take,
    output logic [7:0]       token,
    output logic             reply_valid,
    output logic [1:0]       reply_kind,
    output logic             ovr_err
);
    logic   accept;
    logic   set_tok;
    logic   clr_tok;
    reply_e nxt_kind;

    assign accept = pkt_done && !tx_busy;

    // Decision tree for one accepted packet.
    always_comb begin
        nxt_kind = RPL_NONE;
        set_tok  = 1'b0;
        clr_tok  = 1'b0;
        store_en = 1'b0;
        tx_take  = 1'b0;
        if (accept) begin
            if (!cls.len_ok) begin
                clr_tok = 1'b1;
            end else if (cls.is_data) begin
                if (token == '0) begin
                    clr_tok = 1'b1;
                end else if (rx_len != '0) begin
                    nxt_kind = RPL_NAK;
                end else begin
                    nxt_kind = RPL_ACK;
                    store_en = 1'b1;
                end
            end else if (!cls.addr_ok) begin
                clr_tok = 1'b1;
            end else if (cls.is_in) begin
                if ((tx_len == '0) || (rx_len != '0)) begin
                    nxt_kind = RPL_NAK;
                end else begin
                    nxt_kind = RPL_DATA;
                    tx_take  = 1'b1;
                end
            end else if (cls.is_setup_out) begin
                set_tok = 1'b1;
            end else begin
                clr_tok = 1'b1;
            end
        end
    end

    // Remembered token register.
    always_ff @(posedge clk) begin
        if (!rst_n)       token <= '0;
        else if (set_tok) token <= pid;
        else if (clr_tok) token <= '0;
    end

    // Registered reply request and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_valid <= 1'b0;
            reply_kind  <= RPL_NONE;
            ovr_err     <= 1'b0;
        end else begin
            reply_valid <= (nxt_kind != RPL_NONE);
            reply_kind  <= nxt_kind;
            ovr_err     <= pkt_done && tx_busy;
        end
    end
endmodule

// File: rtl/usbd_dispatcher.sv
// Top level of the packet dispatcher: the classifier, the decision core and
// the buffer state. A reply request is issued one cycle after pkt_done.
module usbd_dispatcher
    import usbd_disp_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       dev_addr,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [7:0]       pkt_pid,
    input  logic [7:0]       pkt_addr,
    input  logic             tx_busy,
    input  logic             rx_release,
    input  logic             tx_load,
    input  logic [LEN_W-1:0] tx_load_len,
    output logic             reply_valid,
    output logic [1:0]       reply_kind,
    output logic             ovr_err,
    output logic [LEN_W-1:0] rx_len,
    output logic [7:0]       rx_token,
    output logic             rx_sel,
    output logic [LEN_W-1:0] tx_len
);
    pkt_class_t cls;
    logic       store_en;
    logic       tx_take;
    logic [7:0] token;

    usbd_pid_decode #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
        .pid       (pkt_pid),
        .addr_byte (pkt_addr),
        .dev_addr  (dev_addr),
        .pkt_len   (pkt_len),
        .cls       (cls)
    );

    usbd_dispatch_core #(.LEN_W(LEN_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_done    (pkt_done),
        .tx_busy     (tx_busy),
        .cls         (cls),
        .pid         (pkt_pid),
        .rx_len      (rx_len),
        .tx_len      (tx_len),
        .store_en    (store_en),
        .tx_take     (tx_take),
        .token       (token),
        .reply_valid (reply_valid),
        .reply_kind  (reply_kind),
        .ovr_err     (ovr_err)
    );

    usbd_buf_state #(.LEN_W(LEN_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_en    (store_en),
        .store_len   (pkt_len),
        .store_tok   (token),
        .tx_take     (tx_take),
        .rx_release  (rx_release),
        .tx_load     (tx_load),
        .tx_load_len (tx_load_len),
        .rx_len      (rx_len),
        .rx_token    (rx_token),
        .rx_sel      (rx_sel),
        .tx_len      (tx_len)
    );
endmodule

// File: rtl/usbd_dispatcher_chk.sv
// Property checker for usbd_dispatcher. It only observes ports and is attached by bind.
module usbd_dispatcher_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_done,
    input logic             tx_busy,
    input logic             rx_release,
    input logic             reply_valid,
    input logic [1:0]       reply_kind,
    input logic             ovr_err,
    input logic [LEN_W-1:0] rx_len,
    input logic             rx_sel,
    input logic [LEN_W-1:0] tx_len
);
    AST_REPLY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> ($past(pkt_done) && !$past(tx_busy)));                  // R11
    AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && tx_busy) |=> (ovr_err && !reply_valid));                  // R12
    AST_ACK_FLIPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && reply_kind == 2'd1) |-> (rx_sel != $past(rx_sel)));    // R8
    AST_ACK_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && reply_kind == 2'd1) |-> ($past(rx_len) == '0));        // R8
    AST_DATA_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && reply_kind == 2'd3) |-> (tx_len == '0 && $past(tx_len) != '0)); // R10
    AST_NAK_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && reply_kind == 2'd2 && !$past(rx_release)) |-> $stable(rx_len)); // R7
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_done && !rx_release) |=> ($stable(rx_len) && $stable(rx_sel)));   // R13
endmodule

bind usbd_dispatcher usbd_dispatcher_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_done    (pkt_done),
    .tx_busy     (tx_busy),
    .rx_release  (rx_release),
    .reply_valid (reply_valid),
    .reply_kind  (reply_kind),
    .ovr_err     (ovr_err),
    .rx_len      (rx_len),
    .rx_sel      (rx_sel),
    .tx_len      (tx_len)
);

// File: tb/usbd_dispatcher_test.sv
// Sweeps every ordered pair of packet types under several firmware buffer
// states, against an arithmetic model of the requirements.
module usbd_dispatcher_test;
    localparam int LEN_W = 4;
    localparam logic [6:0] ADDR = 7'h2A;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_done = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [7:0]       pkt_pid = '0;
    logic [7:0]       pkt_addr = '0;
    logic             tx_busy = 1'b0;
    logic             rx_release = 1'b0;
    logic             tx_load = 1'b0;
    logic [LEN_W-1:0] tx_load_len = '0;
    logic             reply_valid;
    logic [1:0]       reply_kind;
    logic             ovr_err;
    logic [LEN_W-1:0] rx_len;
    logic [7:0]       rx_token;
    logic             rx_sel;
    logic [LEN_W-1:0] tx_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state
    logic [7:0]       m_tok = '0;
    logic [LEN_W-1:0] m_rxlen = '0;
    logic [7:0]       m_rxtok = '0;
    logic             m_sel = 1'b0;
    logic [LEN_W-1:0] m_txlen = '0;

    always #10 clk = ~clk;

    usbd_dispatcher #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .pkt_pid(pkt_pid), .pkt_addr(pkt_addr),
        .tx_busy(tx_busy), .rx_release(rx_release), .tx_load(tx_load),
        .tx_load_len(tx_load_len), .reply_valid(reply_valid),
        .reply_kind(reply_kind), .ovr_err(ovr_err), .rx_len(rx_len),
        .rx_token(rx_token), .rx_sel(rx_sel), .tx_len(tx_len)
    );

    function automatic logic [7:0] pid_of(int k);
        case (k)
            0: return 8'h2D;   // SETUP
            1: return 8'hE1;   // OUT
            2: return 8'h69;   // IN
            3: return 8'hC3;   // DATA0
            4: return 8'h4B;   // DATA1
            5: return 8'hD2;   // ACK handshake from host
            default: return 8'hA5; // SOF
        endcase
    endfunction

    task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] observed();
        return {reply_valid, reply_kind, ovr_err, rx_len, rx_token, rx_sel, tx_len};
    endfunction

    // Send one packet, predict the outcome, check the reply cycle and the next one.
    task automatic send(logic [7:0] pid, logic [7:0] ab, int len, bit busy);
        logic [1:0] ek;
        bit         eerr;
        string      tag;
        ek = 2'd0; eerr = 1'b0;
        if (busy) begin
            eerr = 1'b1; tag = "R12";
        end else if (len < 3) begin
            m_tok = '0; tag = "R2";
        end else if (pid == 8'hC3 || pid == 8'h4B) begin
            if (m_tok == '0) begin
                tag = "R6"; m_tok = '0;
            end else if (m_rxlen != '0) begin
                ek = 2'd2; tag = "R7";
            end else begin
                ek = 2'd1;
                tag = (ab[6:0] != ADDR) ? "R3" : "R8";
                m_rxlen = LEN_W'(len); m_rxtok = m_tok; m_sel = ~m_sel;
            end
        end else if (ab[6:0] != ADDR) begin
            m_tok = '0; tag = "R4";
        end else if (pid == 8'h69) begin
            if (m_txlen == '0 || m_rxlen != '0) begin
                ek = 2'd2; tag = "R9";
            end else begin
                ek = 2'd3; tag = "R10"; m_txlen = '0;
            end
        end else if (pid == 8'h2D || pid == 8'hE1) begin
            m_tok = pid; tag = "R5";
        end else begin
            m_tok = '0; tag = "R4";
        end
        @(negedge clk);
        pkt_done = 1'b1; pkt_pid = pid; pkt_addr = ab;
        pkt_len = LEN_W'(len); tx_busy = busy;
        @(negedge clk);
        pkt_done = 1'b0; tx_busy = 1'b0;
        check(tag, observed(), {(ek != 2'd0), ek, eerr, m_rxlen, m_rxtok, m_sel, m_txlen});
        @(negedge clk);
        check("R11", observed(), {1'b0, 2'd0, 1'b0, m_rxlen, m_rxtok, m_sel, m_txlen});
    endtask

    task automatic release_rx();
        @(negedge clk); rx_release = 1'b1;
        @(negedge clk); rx_release = 1'b0;
        m_rxlen = '0; m_rxtok = '0;
        check("R13", observed(), {4'b0, m_rxlen, m_rxtok, m_sel, m_txlen});
    endtask

    task automatic load_tx(int len);
        @(negedge clk); tx_load = 1'b1; tx_load_len = LEN_W'(len);
        @(negedge clk); tx_load = 1'b0;
        if (m_txlen == '0) m_txlen = LEN_W'(len);
        check("R13", observed(), {4'b0, m_rxlen, m_rxtok, m_sel, m_txlen});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observed(), 21'd0);

        // Pair sweep: first packet, second packet, firmware state variant.
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [7:0] ab1;
                    logic [7:0] ab2;
                    if (v == 1) release_rx();
                    if (v >= 2) load_tx(4 + (b % 4));
                    ab1 = {v[0], (b == 6) ? 7'h2B : ADDR};
                    ab2 = {v[1], (a == 5) ? 7'h55 : ADDR};
                    send(pid_of(a), ab1, (v == 3) ? 2 : 3 + (a % 5), 1'b0);
                    send(pid_of(b), ab2, 3 + (b % 4), 1'b0);
                end
            end
        end

        // Refusal while busy: the token and buffers must survive the strobe.
        for (int k = 0; k < 7; k++) begin
            release_rx();
            load_tx(5);
            send(8'h2D, {1'b0, ADDR}, 3, 1'b0);
            send(pid_of(k), {1'b0, ADDR}, 4, 1'b1);
            send(8'hC3, {1'b0, ADDR}, 6, 1'b0);
            send(8'h69, {1'b0, ADDR}, 3, 1'b1);
            release_rx();
            send(8'h69, {1'b0, ADDR}, 3, 1'b0);
        end

        // Length boundary: 2 bytes are dropped, 3 bytes are accepted.
        release_rx();
        send(8'hE1, {1'b0, ADDR}, 3, 1'b0);
        send(8'h4B, {1'b0, ADDR}, 2, 1'b0);
        send(8'h4B, {1'b0, ADDR}, 3, 1'b0);
        send(8'hE1, {1'b0, ADDR}, 2, 1'b0);
        send(8'hC3, {1'b0, ADDR}, 3, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule